// File: doc/BRIEF.md
# Two-Step Single-Slope Converter Column Logic

This block is the digital half of one column of a two-step single-slope analog-to-digital converter. A conversion has two phases. In the coarse phase a staircase ramp is stepped once per clock, and a coarse counter advances until the column comparator reports that the ramp has crossed the pixel level. In the fine phase one shared fine ramp is swept and a fine counter runs until the comparator trips a second time. The coarse decision exists only as a count. No analog value is held between the two phases.

The coarse count is decoded to a one-hot segment select, which picks the coarse segment used as the reference for the fine sweep. The fine sweep is identical for every coarse result. It covers one coarse step plus one step of overlap. A correction stage adds the fine count to the coarse count weighted by the fine range. It then removes half of a coarse step and clamps the result to the 12-bit output range, which absorbs an early or late coarse decision.

Results leave on a valid/ready stream. A result is presented the cycle after the fine strobe falls. It is held unchanged while `code_ready_i` is low and is retired in the cycle after a handshake. A new start strobe discards a result that has not been accepted.

Top module: `sscol_two_step`

## Requirements
- R1: After reset, `code_valid_o` and `done_o` are low and `seg_sel_o` equals 1, which is segment 0.
- R2: A cycle with `start_i` high clears both counters and their trip flags. In the next cycle `code_valid_o` is low, even if a result was still waiting.
- R3: The coarse count is the number of cycles with `coarse_en_i` high and `cmp_i` low before the first cycle with both high. Comparator activity after that first trip is ignored. If the comparator never trips, the count stops at 15.
- R4: `seg_sel_o` is one-hot, with bit k set exactly when the coarse count equals k.
- R5: The fine count follows the rule of R3 under `fine_en_i`. It stops at 511, which is one coarse step plus one overlap step.
- R6: The output code is coarse*256 + fine - 128. It is clamped to 0 when this value is negative and to 4095 when it is above 4095.
- R7: In the cycle after `fine_en_i` goes from high to low, `code_valid_o` is high with the corrected code, and `done_o` is high for exactly that one cycle.
- R8: While `code_valid_o` is high and `code_ready_i` is low, `code_valid_o` and `code_o` hold their values. After a cycle with both high, `code_valid_o` is low unless a new result is loaded in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion start strobe |
| coarse_en_i | input | 1 | High during the coarse ramp phase |
| fine_en_i | input | 1 | High during the fine ramp phase |
| cmp_i | input | 1 | Column comparator output, high when the ramp is past the input |
| code_ready_i | input | 1 | Downstream accepts the code |
| code_valid_o | output | 1 | Corrected code is available |
| code_o | output | 12 | Corrected conversion result |
| done_o | output | 1 | One-cycle pulse when a new result becomes valid |
| seg_sel_o | output | 16 | One-hot coarse segment select |

## Verification
The assertions assume that the sequencer never raises the two phase strobes together. They also assume that start arrives only while both strobes are low and that each fine phase is preceded by a coarse phase and a start. The stimulus comes from a single conversion task that applies start, then the coarse window, then one idle cycle, then the fine window, so these orderings hold throughout the run. Inside each window the comparator is modelled as a level that rises at a chosen step, with an optional one-cycle dip after the rise and an optional refusal to trip at all. Back-pressure is applied by holding ready low across one result and by issuing a start over a result that has not been accepted.

// File: rtl/sscol_pkg.sv
package sscol_pkg;
  localparam int unsigned COARSE_W_DEF = 4;
  localparam int unsigned FINE_W_DEF   = 8;
  localparam int unsigned OVL_W_DEF    = 1;
  localparam int unsigned OUT_W_DEF    = COARSE_W_DEF + FINE_W_DEF;
endpackage

// File: rtl/sscol_step_counter.sv
module sscol_step_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic         cmp_i,
  output logic [W-1:0] count_o,
  output logic         tripped_o
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o   <= '0;
      tripped_o <= 1'b0;
    end else if (clear_i) begin
      count_o   <= '0;
      tripped_o <= 1'b0;
    end else if (en_i && !tripped_o) begin
      if (cmp_i)
        tripped_o <= 1'b1;
      else if (count_o != FULL)
        count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/sscol_seg_decoder.sv
module sscol_seg_decoder #(
  parameter int unsigned IN_W = 4,
  localparam int unsigned SEGS = 1 << IN_W
) (
  input  logic [IN_W-1:0] idx_i,
  output logic [SEGS-1:0] onehot_o
);
  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    assign onehot_o[g] = (idx_i == IN_W'(g));
  end
endmodule

// File: rtl/sscol_merge.sv
module sscol_merge #(
  parameter int unsigned COARSE_W = 4,
  parameter int unsigned FINE_W   = 8,
  parameter int unsigned OVL_W    = 1,
  localparam int unsigned FCNT_W  = FINE_W + OVL_W,
  localparam int unsigned OUT_W   = COARSE_W + FINE_W,
  localparam int unsigned SUM_W   = OUT_W + OVL_W + 1
) (
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FCNT_W-1:0]   fine_i,
  output logic [OUT_W-1:0]    code_o
);
  localparam logic [SUM_W-1:0] HALF_STEP = SUM_W'(1) << (FINE_W - 1);
  localparam logic [SUM_W-1:0] TOP_CODE  = SUM_W'({OUT_W{1'b1}});

  logic [SUM_W-1:0] raw;
  logic [SUM_W-1:0] shifted;

  always_comb begin
    raw     = (SUM_W'(coarse_i) << FINE_W) + SUM_W'(fine_i);
    shifted = raw - HALF_STEP;
    if (raw < HALF_STEP)
      code_o = '0;
    else if (shifted > TOP_CODE)
      code_o = {OUT_W{1'b1}};
    else
      code_o = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/sscol_two_step.sv
module sscol_two_step
  import sscol_pkg::*;
#(
  parameter int unsigned COARSE_W = COARSE_W_DEF,
  parameter int unsigned FINE_W   = FINE_W_DEF,
  parameter int unsigned OVL_W    = OVL_W_DEF,
  localparam int unsigned FCNT_W  = FINE_W + OVL_W,
  localparam int unsigned OUT_W   = COARSE_W + FINE_W,
  localparam int unsigned SEGS    = 1 << COARSE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             coarse_en_i,
  input  logic             fine_en_i,
  input  logic             cmp_i,
  input  logic             code_ready_i,
  output logic             code_valid_o,
  output logic [OUT_W-1:0] code_o,
  output logic             done_o,
  output logic [SEGS-1:0]  seg_sel_o
);
  logic [COARSE_W-1:0] coarse_cnt;
  logic [FCNT_W-1:0]   fine_cnt;
  logic                coarse_hit;
  logic                fine_hit;
  logic                fine_en_q;
  logic                fine_end;
  logic [OUT_W-1:0]    merged;

  sscol_step_counter #(.W(COARSE_W)) coarse_ctr_i (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .en_i(coarse_en_i),
    .cmp_i(cmp_i), .count_o(coarse_cnt), .tripped_o(coarse_hit)
  );

  sscol_step_counter #(.W(FCNT_W)) fine_ctr_i (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .en_i(fine_en_i),
    .cmp_i(cmp_i), .count_o(fine_cnt), .tripped_o(fine_hit)
  );

  sscol_seg_decoder #(.IN_W(COARSE_W)) seg_dec_i (
    .idx_i(coarse_cnt), .onehot_o(seg_sel_o)
  );

  sscol_merge #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .OVL_W(OVL_W)) merge_i (
    .coarse_i(coarse_cnt), .fine_i(fine_cnt), .code_o(merged)
  );

  assign fine_end = fine_en_q && !fine_en_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fine_en_q    <= 1'b0;
      code_valid_o <= 1'b0;
      code_o       <= '0;
      done_o       <= 1'b0;
    end else begin
      fine_en_q <= fine_en_i;
      done_o    <= 1'b0;
      if (start_i) begin
        code_valid_o <= 1'b0;
      end else if (fine_end) begin
        code_o       <= merged;
        code_valid_o <= 1'b1;
        done_o       <= 1'b1;
      end else if (code_valid_o && code_ready_i) begin
        code_valid_o <= 1'b0;
      end
    end
  end

  logic unused_hits;
  assign unused_hits = coarse_hit ^ fine_hit;
endmodule

// File: rtl/sscol_two_step_chk.sv
module sscol_two_step_chk #(
  parameter int unsigned OUT_W = 12,
  parameter int unsigned SEGS  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             code_ready_i,
  input logic             code_valid_o,
  input logic [OUT_W-1:0] code_o,
  input logic             done_o,
  input logic [SEGS-1:0]  seg_sel_o
);
  AST_SEG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_sel_o) == 1); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> code_valid_o); // R7

  AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !code_valid_o); // R2

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid_o && !code_ready_i && !start_i) |=> (code_valid_o && $stable(code_o))); // R8

  AST_ACCEPT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid_o && code_ready_i && !start_i) |=> (!code_valid_o || done_o)); // R8
endmodule

bind sscol_two_step sscol_two_step_chk #(.OUT_W(OUT_W), .SEGS(SEGS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_ready_i(code_ready_i),
  .code_valid_o(code_valid_o), .code_o(code_o), .done_o(done_o),
  .seg_sel_o(seg_sel_o)
);

// File: tb/sscol_two_step_tb.sv
module sscol_two_step_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        coarse_en_i = 1'b0;
  logic        fine_en_i = 1'b0;
  logic        cmp_i = 1'b0;
  logic        code_ready_i = 1'b1;
  logic        code_valid_o;
  logic [11:0] code_o;
  logic        done_o;
  logic [15:0] seg_sel_o;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int  m_c = 0, m_f = 0, m_code = 0;
  bit  m_ct = 0, m_ft = 0, m_valid = 0, m_done = 0, m_fprev = 0;

  sscol_two_step dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .coarse_en_i(coarse_en_i),
    .fine_en_i(fine_en_i), .cmp_i(cmp_i), .code_ready_i(code_ready_i),
    .code_valid_o(code_valid_o), .code_o(code_o), .done_o(done_o),
    .seg_sel_o(seg_sel_o)
  );

  always #5 clk = ~clk;

  function automatic int corr(input int c, input int f);
    int v;
    v = c * 256 + f - 128;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c = 0; m_f = 0; m_ct = 0; m_ft = 0;
      m_valid = 0; m_done = 0; m_code = 0; m_fprev = 0;
    end else begin
      m_done = 0;
      if (start_i) m_valid = 0;
      else if (m_fprev && !fine_en_i) begin
        m_code = corr(m_c, m_f); m_valid = 1; m_done = 1;
      end else if (m_valid && code_ready_i) m_valid = 0;
      if (start_i) begin
        m_c = 0; m_f = 0; m_ct = 0; m_ft = 0;
      end else begin
        if (coarse_en_i && !m_ct) begin
          if (cmp_i) m_ct = 1; else if (m_c < 15) m_c++;
        end
        if (fine_en_i && !m_ft) begin
          if (cmp_i) m_ft = 1; else if (m_f < 511) m_f++;
        end
      end
      m_fprev = fine_en_i;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(code_valid_o == m_valid, "R7/R8 valid", int'(code_valid_o), int'(m_valid));
      check(done_o == m_done, "R7 done", int'(done_o), int'(m_done));
      check(seg_sel_o == 16'(1 << m_c), "R4 seg_sel", int'(seg_sel_o), 1 << m_c);
      if (m_valid)
        check(int'(code_o) == m_code, "R6 code", int'(code_o), m_code);
    end
  end

  task automatic convert(input int ctrip, input bit cglitch, input int ftrip, input int flen);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      coarse_en_i = 1'b1;
      cmp_i = (ctrip >= 0 && i >= ctrip) ^ (cglitch && i == ctrip + 1);
      @(negedge clk);
    end
    coarse_en_i = 1'b0; cmp_i = 1'b0;
    @(negedge clk);
    for (int i = 0; i < flen; i++) begin
      fine_en_i = 1'b1;
      cmp_i = (ftrip >= 0 && i >= ftrip);
      @(negedge clk);
    end
    fine_en_i = 1'b0; cmp_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_result(input string req, input int exp);
    check(code_valid_o === 1'b1, {req, " valid after fine end"}, int'(code_valid_o), 1);
    check(int'(code_o) == exp, {req, " code"}, int'(code_o), exp);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(code_valid_o == 1'b0, "R1 valid", int'(code_valid_o), 0);
    check(done_o == 1'b0, "R1 done", int'(done_o), 0);
    check(seg_sel_o == 16'h0001, "R1 seg_sel", int'(seg_sel_o), 1);

    // R3 R5 R6 nominal
    convert(5, 0, 200, 300);
    expect_result("R3/R5/R6 nominal", corr(5, 200));
    check(seg_sel_o == 16'h0020, "R4 segment 5", int'(seg_sel_o), 32);
    // R6 low clamp
    convert(0, 0, 10, 100);
    expect_result("R6 low clamp", 0);
    // R3 R5 saturation and R6 high clamp
    convert(-1, 0, -1, 520);
    expect_result("R3/R5 saturation R6 high clamp", 4095);
    check(seg_sel_o == 16'h8000, "R3 coarse saturates at 15", int'(seg_sel_o), 32768);
    // immediate fine trip
    convert(3, 0, 0, 50);
    expect_result("R5 immediate trip", corr(3, 0));
    // R3 later comparator dip ignored
    convert(7, 1, 300, 400);
    expect_result("R3 dip ignored", corr(7, 300));

    // R8 back-pressure
    code_ready_i = 1'b0;
    convert(9, 0, 77, 120);
    expect_result("R8 stalled", corr(9, 77));
    repeat (5) @(negedge clk);
    expect_result("R8 held", corr(9, 77));
    code_ready_i = 1'b1;
    @(negedge clk);
    check(code_valid_o == 1'b0, "R8 retired after accept", int'(code_valid_o), 0);

    // R2 start drops pending result
    code_ready_i = 1'b0;
    convert(12, 0, 256, 300);
    expect_result("R2 pending", corr(12, 256));
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(code_valid_o == 1'b0, "R2 start drops result", int'(code_valid_o), 0);
    check(seg_sel_o == 16'h0001, "R2 counters cleared", int'(seg_sel_o), 1);
    code_ready_i = 1'b1;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule